// File: doc/BRIEF.md
# One-Bit ALU Slice with Less-Than Pass-Through and Hex Readout

This block is a single bit of a ripple-chained arithmetic/logic unit. Two data bits, each of which can be complemented on request, feed an AND gate, an OR gate and a full adder. A two-bit operation code then picks which of four values reaches the result pin. Code 3 passes in a less-than bit from outside the slice. When slices are chained, the most significant slice sends its adder sum back to the least significant slice through that input, which builds a set-less-than operation.

The adder's sum and carry always appear on their own pins, whatever operation is chosen. A carry chain or a sign tap therefore never depends on the operation code. A small wrapper packs the three outputs into a nibble and drives an active-low seven-segment digit, so a bench or a board can show the slice state as one digit from 0 to 7. The block has no clock and no state.

Top module: `alu_bitslice_view`

## Requirements
- R1: The operands used by every operation are `opa = a ^ inv_a` and `opb = b ^ neg_b`.
- R2: With `op_sel` = 2'b00, `res` equals `opa & opb`.
- R3: With `op_sel` = 2'b01, `res` equals `opa | opb`.
- R4: With `op_sel` = 2'b10, `res` equals the adder sum `opa ^ opb ^ carry_in`.
- R5: With `op_sel` = 2'b11, `res` equals `less_in`, whatever the data inputs are.
- R6: `sum_out` always equals `opa ^ opb ^ carry_in`, for every `op_sel`.
- R7: `carry_out` always equals the majority of `opa`, `opb` and `carry_in`, for every `op_sel`.
- R8: `digit` is `{1'b0, sum_out, carry_out, res}`, with bit 3 the most significant bit, so its value never exceeds 7.
- R9: `seg_n[6:0]` drives segments g..a, with bit 6 = g and bit 0 = a, active low. For the digit values 0 to 7 it shows the patterns 7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02 and 7'h78.
- R10: Every output depends only on the present inputs. Applying an earlier input pattern again gives the same outputs, with no effect from the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 1 | Data bit A |
| b | input | 1 | Data bit B |
| carry_in | input | 1 | Carry into the adder |
| inv_a | input | 1 | Complement A before use |
| neg_b | input | 1 | Complement B before use |
| less_in | input | 1 | External less-than bit, routed to `res` by code 3 |
| op_sel | input | 2 | Operation code: 0 AND, 1 OR, 2 sum, 3 less-than pass |
| res | output | 1 | Selected result bit |
| carry_out | output | 1 | Adder carry out |
| sum_out | output | 1 | Raw adder sum, for the less-than chain |
| digit | output | 4 | Packed nibble {0, sum_out, carry_out, res} |
| seg_n | output | 7 | Active-low segments g..a for `digit` |

## Verification
The slice holds no state, so any fault shows at the ports in the same settling time as the input change that exposes it. A wrong operand conditioning or adder term shows up on `sum_out` and `carry_out` under every operation code, even when `res` looks correct. A wrong select decode shows up only on `res`, and only for the code that is affected. Driving all 256 input combinations against an independent model in the bench, together with the known digit examples, leaves no input pattern that a fault could hide behind.

// File: rtl/alu_bitslice_pkg.sv
package alu_bitslice_pkg;
  localparam int OP_W   = 2;
  localparam int NIB_W  = 4;
  localparam int SEG_W  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } op_e;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond (
  input  logic a,
  input  logic b,
  input  logic inv_a,
  input  logic neg_b,
  output logic opa,
  output logic opb
);
  // R1: optional complement of each data bit
  assign opa = a ^ inv_a;
  assign opb = b ^ neg_b;
endmodule

// File: rtl/alu_full_add.sv
module alu_full_add (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;
  assign half = x ^ y;
  assign s    = half ^ ci;
  assign co   = (x & y) | (half & ci);

  // R7: a carry needs at least two ones among the adder inputs
  always_comb begin
    a_r7_carry_majority: assert ((co == 1'b0) || ($countones({x, y, ci}) >= 2))
      else $error("carry raised with fewer than two ones");
  end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_bitslice_pkg::*;
(
  input  logic [OP_W-1:0] sel,
  input  logic            and_v,
  input  logic            or_v,
  input  logic            sum_v,
  input  logic            less_v,
  output logic            y
);
  logic [(1<<OP_W)-1:0] choices;
  assign choices = {less_v, sum_v, or_v, and_v};

  always_comb begin
    unique case (op_e'(sel))
      OP_AND:  y = choices[0];
      OP_OR:   y = choices[1];
      OP_SUM:  y = choices[2];
      default: y = choices[3];
    endcase
  end

  // R5: code 3 passes the external less-than bit
  always_comb begin
    a_r5_less_pass: assert ((sel != OP_LESS) || (y == less_v))
      else $error("less-than bit not passed");
  end
endmodule

// File: rtl/hex_seg_dec.sv
module hex_seg_dec
  import alu_bitslice_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic [NIB_W-1:0] val,
  output logic [SEG_W-1:0] seg
);
  logic [SEG_W-1:0] on_pat;   // g..a, 1 = lit

  always_comb begin
    case (val)
      4'h0: on_pat = 7'h3F;
      4'h1: on_pat = 7'h06;
      4'h2: on_pat = 7'h5B;
      4'h3: on_pat = 7'h4F;
      4'h4: on_pat = 7'h66;
      4'h5: on_pat = 7'h6D;
      4'h6: on_pat = 7'h7D;
      4'h7: on_pat = 7'h07;
      4'h8: on_pat = 7'h7F;
      4'h9: on_pat = 7'h6F;
      4'hA: on_pat = 7'h77;
      4'hB: on_pat = 7'h7C;
      4'hC: on_pat = 7'h39;
      4'hD: on_pat = 7'h5E;
      4'hE: on_pat = 7'h79;
      default: on_pat = 7'h71;
    endcase
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg = ~on_pat;
    end else begin : g_high
      assign seg = on_pat;
    end
  endgenerate
endmodule

// File: rtl/alu_bitslice_view.sv
module alu_bitslice_view
  import alu_bitslice_pkg::*;
(
  input  logic                a,
  input  logic                b,
  input  logic                carry_in,
  input  logic                inv_a,
  input  logic                neg_b,
  input  logic                less_in,
  input  logic [OP_W-1:0]     op_sel,
  output logic                res,
  output logic                carry_out,
  output logic                sum_out,
  output logic [NIB_W-1:0]    digit,
  output logic [SEG_W-1:0]    seg_n
);
  logic opa, opb;
  logic and_v, or_v;

  alu_operand_cond u_cond (
    .a(a), .b(b), .inv_a(inv_a), .neg_b(neg_b), .opa(opa), .opb(opb)
  );

  assign and_v = opa & opb;
  assign or_v  = opa | opb;

  alu_full_add u_add (
    .x(opa), .y(opb), .ci(carry_in), .s(sum_out), .co(carry_out)
  );

  alu_result_mux u_mux (
    .sel(op_sel), .and_v(and_v), .or_v(or_v), .sum_v(sum_out),
    .less_v(less_in), .y(res)
  );

  // R8: packed view, top bit tied low
  assign digit = {1'b0, sum_out, carry_out, res};

  hex_seg_dec #(.ACTIVE_LOW(1'b1)) u_seg (
    .val(digit), .seg(seg_n)
  );

  always_comb begin
    // R2: AND result can be high only if both operands are high
    a_r2_and_needs_both: assert ((op_sel != OP_AND) || !res || (opa && opb))
      else $error("AND result high without both operands");
    // R3: OR result low only when both operands are low
    a_r3_or_needs_none: assert ((op_sel != OP_OR) || res || (!opa && !opb))
      else $error("OR result low with an operand high");
    // R6: adder sum tracks operand parity under every code
    a_r6_sum_parity: assert (sum_out == ^{opa, opb, carry_in})
      else $error("sum does not match operand parity");
    // R9: digits 0..7 never blank the display
    a_r9_seg_not_blank: assert (seg_n != 7'h7F)
      else $error("segment pattern blank");
  end
endmodule

// File: tb/alu_bitslice_view_tb_top.sv
module alu_bitslice_view_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic a, b, carry_in, inv_a, neg_b, less_in;
  logic [1:0] op_sel;
  logic res, carry_out, sum_out;
  logic [3:0] digit;
  logic [6:0] seg_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  alu_bitslice_view dut_i (
    .a(a), .b(b), .carry_in(carry_in), .inv_a(inv_a), .neg_b(neg_b),
    .less_in(less_in), .op_sel(op_sel), .res(res), .carry_out(carry_out),
    .sum_out(sum_out), .digit(digit), .seg_n(seg_n)
  );

  function automatic logic [6:0] seg_ref(input logic [2:0] d);
    case (d)
      3'd0: return 7'h40;
      3'd1: return 7'h79;
      3'd2: return 7'h24;
      3'd3: return 7'h30;
      3'd4: return 7'h19;
      3'd5: return 7'h12;
      3'd6: return 7'h02;
      default: return 7'h78;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // pattern bits: [7]less [6]a [5]b [4]cin [3]inv_a [2]neg_b [1:0]op
  task automatic apply(input logic [7:0] p);
    @(negedge clk);
    {less_in, a, b, carry_in, inv_a, neg_b, op_sel} = p;
    #5;
  endtask

  task automatic check_model(input logic [7:0] p);
    logic oa, ob, s, c, r;
    oa = p[6] ^ p[3];
    ob = p[5] ^ p[2];
    s  = oa ^ ob ^ p[4];
    c  = (oa & ob) | (oa & p[4]) | (ob & p[4]);
    case (p[1:0])
      2'b00: r = oa & ob;
      2'b01: r = oa | ob;
      2'b10: r = s;
      default: r = p[7];
    endcase
    apply(p);
    case (p[1:0])
      2'b00: chk("R2/R1 res", res, r);
      2'b01: chk("R3/R1 res", res, r);
      2'b10: chk("R4/R1 res", res, r);
      default: chk("R5 res", res, r);
    endcase
    chk("R6 sum_out", sum_out, s);
    chk("R7 carry_out", carry_out, c);
    chk("R8 digit", digit, {1'b0, s, c, r});
    chk("R9 seg_n", seg_n, seg_ref({s, c, r}));
  endtask

  task automatic t_idle;
    apply(8'h00);
    chk("R8 idle digit", digit, 0);
    chk("R9 idle seg", seg_n, 7'h40);
  endtask

  task automatic t_examples;
    apply(8'b0100_0000);   // A=1, AND
    chk("R6 AND side sum digit", digit, 4);
    apply(8'b0100_0001);   // A=1, OR
    chk("R3 OR digit", digit, 5);
    apply(8'b1111_0111);   // less=1, A=B=Cin=1, neg_b, code 3
    chk("R5 sub digit", digit, 3);
    apply(8'b1111_1111);   // both inverted, code 3
    chk("R5 both-inv digit", digit, 5);
    chk("R9 digit5 seg", seg_n, 7'h12);
  endtask

  task automatic t_less_ignores_data;
    for (int i = 0; i < 64; i++) begin
      apply({1'b0, i[5:0], 1'b0} | 8'h03);
      chk("R5 less=0 res", res, 0);
    end
  endtask

  task automatic t_exhaustive;
    for (int i = 0; i < 256; i++) check_model(i[7:0]);
  endtask

  task automatic t_history;
    apply(8'b0110_1010);
    begin
      logic [6:0] first;
      first = seg_n;
      apply(8'b1001_0111);
      apply(8'b0110_1010);
      chk("R10 repeat seg", seg_n, first);
    end
  endtask

  initial begin
    {less_in, a, b, carry_in, inv_a, neg_b, op_sel} = '0;
    t_idle();
    t_examples();
    t_less_ignores_data();
    t_exhaustive();
    t_history();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule